// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Store Access Controller

This block gives a processor single-byte access to a 4096-byte nonvolatile data store through four registers on a simple I/O bus. The registers hold a 12-bit address, split into a low and a high register, a data byte and a control byte. Software writes the address and, for a store, the data byte. It then triggers a load or a store through the control register.

A load copies the addressed byte into the data register and holds the processor in a halt for four cycles. A store is accepted only when an arming bit was set shortly before the strobe. It holds the processor for two cycles and then completes in the background over a fixed number of cycles. During that time a busy flag can be polled. When the store finishes, the block pulses a ready interrupt if that interrupt is enabled. A low-supply input prevents new stores from starting but never cuts short a store that is already running.

Top module: `nvbyte_ctrl`

## Requirements
- R1: A byte stored at a 12-bit address is returned by a later load from that same address. The low address register (bus_reg=2) holds address bits 7..0. Bits 3..0 of the high address register (bus_reg=3) hold address bits 11..8. The data register is bus_reg=0 and the control register is bus_reg=1.
- R2: Bits 7..4 of the high address register always read as 0, whatever value was written to them.
- R3: A control write with bit 0 set and bit 1 clear is a load strobe. It copies the addressed byte into the data register. From the cycle after the strobe, cpu_halt is high for exactly 4 cycles.
- R4: An accepted store strobe (control bit 1) drives cpu_halt high for exactly 2 cycles, starting the cycle after the strobe.
- R5: After an accepted store strobe, control bit 1 reads 1 for exactly WR_LAT cycles (default 6), starting the cycle after the strobe. The store is then complete.
- R6: A control write with bit 1 clear sets the arm flag (control bit 2) to bit 2 of the written value. A store strobe is accepted only if it lands in one of the 4 cycles that follow the arming write. After those 4 cycles the arm flag clears by itself. Any store strobe, accepted or not, also clears the arm flag.
- R7: A load strobe issued while a store is busy is ignored: there is no halt and the data register is unchanged.
- R8: Writes to the data register or to either address register are ignored while a store is busy.
- R9: If control bit 3 (interrupt enable) is set, ready_irq is high for exactly one cycle: the first cycle in which busy reads 0 after a store. With the enable clear, ready_irq stays low.
- R10: While supply_low is high, a store strobe is not accepted. A store already in progress still completes and updates the byte.
- R11: After reset, cpu_halt and ready_irq are 0, the control register reads 0 and the data register reads 0. The 12 address bits take an arbitrary value that software must not rely on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe for this cycle |
| bus_reg | input | 2 | Register select: 0 data, 1 control, 2 address low, 3 address high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register, combinational |
| supply_low | input | 1 | Low-supply inhibit for starting stores |
| cpu_halt | output | 1 | Halt request to the processor pipeline |
| ready_irq | output | 1 | One-cycle store-complete interrupt pulse |

## Verification
The halt-length check assumes that software issues no new strobe while the processor is halted, because a strobe in that state would restart the halt counter. The busy-length check assumes the same of store strobes while a store runs; those strobes are blocked anyway. The stimulus respects both assumptions: every strobe is followed by idle cycles that last longer than the halt and, where a store was started, longer than the store. Register writes during a busy store are sent on purpose, but only to the data and address registers and as load strobes, which the design must reject.

// File: rtl/nvbyte_pkg.sv
package nvbyte_pkg;
    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_CTRL = 2'd1,
        REG_ADLO = 2'd2,
        REG_ADHI = 2'd3
    } reg_sel_e;

    localparam int CB_RSTB = 0;   // load strobe
    localparam int CB_WSTB = 1;   // store strobe / busy readback
    localparam int CB_ARM  = 2;   // arm flag
    localparam int CB_IEN  = 3;   // ready interrupt enable
endpackage

// File: rtl/nvbyte_stall.sv
module nvbyte_stall #(
    parameter int MAX_LEN = 4,
    localparam int CW = $clog2(MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          halt
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = len;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign halt = (cnt_q != '0);
endmodule

// File: rtl/nvbyte_array.sv
module nvbyte_array #(
    parameter int ADDR_W = 12,
    parameter int WR_LAT = 6,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int LW    = $clog2(WR_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        logic              busy;
        logic [LW-1:0]     cnt;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } job_t;

    job_t job_d, job_q;
    logic [7:0] mem [DEPTH];

    always_comb begin
        job_d = job_q;
        if (start) begin
            job_d.busy = 1'b1;
            job_d.cnt  = LW'(WR_LAT);
            job_d.addr = wr_addr;
            job_d.data = wr_data;
        end else if (job_q.busy) begin
            job_d.cnt = job_q.cnt - 1'b1;
            if (job_q.cnt == LW'(1))
                job_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) job_q <= '0;
        else        job_q <= job_d;
    end

    always_ff @(posedge clk) begin
        if (done)
            mem[job_q.addr] <= job_q.data;
    end

    assign busy    = job_q.busy;
    assign done    = job_q.busy && (job_q.cnt == LW'(1));
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl
    import nvbyte_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int WR_LAT  = 6,
    parameter int RD_HALT = 4,
    parameter int WR_HALT = 2,
    parameter int ARM_WIN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic [1:0] bus_reg,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       supply_low,
    output logic       cpu_halt,
    output logic       ready_irq
);
    localparam int HI_W    = ADDR_W - 8;
    localparam int MAX_HLT = (RD_HALT > WR_HALT) ? RD_HALT : WR_HALT;
    localparam int HW      = $clog2(MAX_HLT + 1);
    localparam int AW      = $clog2(ARM_WIN + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              arm;
        logic [AW-1:0]     arm_cnt;
        logic              irq_en;
        logic              irq;
    } st_t;

    st_t st_d, st_q;

    logic          wr_busy, wr_done;
    logic [7:0]    arr_rdata;
    logic          ctrl_wr, wr_go, rd_go;
    logic [HW-1:0] halt_len;
    logic [ADDR_W-1:0] addr_cur;
    logic [7:0]    data_cur;

    always_comb begin
        ctrl_wr = bus_we && (bus_reg == REG_CTRL);
        wr_go   = ctrl_wr && bus_wdata[CB_WSTB] && st_q.arm && !wr_busy && !supply_low;
        rd_go   = ctrl_wr && bus_wdata[CB_RSTB] && !bus_wdata[CB_WSTB] && !wr_busy;
        halt_len = wr_go ? HW'(WR_HALT) : HW'(RD_HALT);

        st_d     = st_q;
        st_d.irq = wr_done && st_q.irq_en;

        if (st_q.arm) begin
            if (st_q.arm_cnt == AW'(1))
                st_d.arm = 1'b0;
            else
                st_d.arm_cnt = st_q.arm_cnt - 1'b1;
        end

        if (bus_we && !wr_busy) begin
            case (bus_reg)
                REG_DATA: st_d.data = bus_wdata;
                REG_ADLO: st_d.addr[7:0] = bus_wdata;
                REG_ADHI: st_d.addr[ADDR_W-1:8] = bus_wdata[HI_W-1:0];
                default:  ;
            endcase
        end

        if (ctrl_wr) begin
            st_d.irq_en = bus_wdata[CB_IEN];
            if (bus_wdata[CB_WSTB]) begin
                st_d.arm = 1'b0;
            end else begin
                st_d.arm     = bus_wdata[CB_ARM];
                st_d.arm_cnt = AW'(ARM_WIN);
            end
        end

        if (rd_go)
            st_d.data = arr_rdata;
    end

    // The address reset value is arbitrary; software must load it before use.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    nvbyte_array #(
        .ADDR_W (ADDR_W),
        .WR_LAT (WR_LAT)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (wr_go),
        .wr_addr (st_q.addr),
        .wr_data (st_q.data),
        .rd_addr (st_q.addr),
        .rd_data (arr_rdata),
        .busy    (wr_busy),
        .done    (wr_done)
    );

    nvbyte_stall #(
        .MAX_LEN (MAX_HLT)
    ) u_stall (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_go || rd_go),
        .len   (halt_len),
        .halt  (cpu_halt)
    );

    always_comb begin
        case (bus_reg)
            REG_DATA: bus_rdata = st_q.data;
            REG_CTRL: bus_rdata = {4'b0, st_q.irq_en, st_q.arm, wr_busy, 1'b0};
            REG_ADLO: bus_rdata = st_q.addr[7:0];
            default:  bus_rdata = {{(8 - HI_W){1'b0}}, st_q.addr[ADDR_W-1:8]};
        endcase
    end

    assign ready_irq = st_q.irq;
    assign addr_cur  = st_q.addr;
    assign data_cur  = st_q.data;
endmodule

// File: rtl/nvbyte_ctrl_chk.sv
module nvbyte_ctrl_chk #(
    parameter int ADDR_W  = 12,
    parameter int WR_LAT  = 6,
    parameter int RD_HALT = 4,
    parameter int WR_HALT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_reg,
    input  logic              strobe_bit,
    input  logic [7:0]        bus_rdata,
    input  logic              supply_low,
    input  logic              cpu_halt,
    input  logic              ready_irq,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr_cur,
    input  logic [7:0]        data_cur
);
    logic [15:0] halt_run, busy_run;
    logic        halt_prev, busy_prev;

    // R2: reserved high-address bits read as zero
    p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reg == 2'd3) |-> (bus_rdata[7:4] == 4'h0));

    // R7 and R8: address and data registers frozen while a store runs
    p_frozen_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(addr_cur) && $stable(data_cur)));

    // R10: inhibit blocks a store from starting
    p_inhibit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_reg == 2'd1 && strobe_bit && supply_low && !busy) |=> !busy);

    // R9: interrupt pulse only right after busy falls
    p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ready_irq |-> (!busy && $past(busy)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_run  <= '0;
            busy_run  <= '0;
            halt_prev <= 1'b0;
            busy_prev <= 1'b0;
        end else begin
            halt_prev <= cpu_halt;
            busy_prev <= busy;
            halt_run  <= cpu_halt ? halt_run + 1'b1 : '0;
            busy_run  <= busy ? busy_run + 1'b1 : '0;
            // R3 and R4: halt runs last exactly one of the two fixed lengths
            if (halt_prev && !cpu_halt)
                p_halt_len_r3: assert (halt_run == 16'(RD_HALT) || halt_run == 16'(WR_HALT))
                    else $error("halt run of %0d cycles", halt_run);
            // R5: busy lasts exactly the write latency
            if (busy_prev && !busy)
                p_busy_len_r5: assert (busy_run == 16'(WR_LAT))
                    else $error("busy run of %0d cycles", busy_run);
        end
    end
endmodule

bind nvbyte_ctrl nvbyte_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .WR_LAT  (WR_LAT),
    .RD_HALT (RD_HALT),
    .WR_HALT (WR_HALT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_reg    (bus_reg),
    .strobe_bit (bus_wdata[1]),
    .bus_rdata  (bus_rdata),
    .supply_low (supply_low),
    .cpu_halt   (cpu_halt),
    .ready_irq  (ready_irq),
    .busy       (wr_busy),
    .addr_cur   (addr_cur),
    .data_cur   (data_cur)
);

// File: tb/nvbyte_ctrl_tb.sv
module nvbyte_ctrl_tb;
    localparam int CLK_P   = 10;
    localparam int WR_LAT  = 6;
    localparam int RD_HALT = 4;
    localparam int WR_HALT = 2;
    localparam int ARM_WIN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_reg = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic       supply_low = 1'b0;
    logic [7:0] bus_rdata;
    logic       cpu_halt, ready_irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R11";
    bit    ie_bit = 1'b0;
    bit    finished = 1'b0;

    // behavioural reference state
    byte unsigned mem [int];
    int  m_addr = 0;
    bit  m_addr_known = 0;
    int  m_data = 0;
    bit  m_data_known = 1;
    bit  m_arm = 0;
    int  m_win = 0;
    bit  m_ie = 0;
    bit  m_irq = 0;
    int  m_halt = 0;
    int  m_busy = 0;
    int  m_pa = 0;
    int  m_pd = 0;

    always #(CLK_P/2) clk = ~clk;

    nvbyte_ctrl #(
        .WR_LAT  (WR_LAT),
        .RD_HALT (RD_HALT),
        .WR_HALT (WR_HALT),
        .ARM_WIN (ARM_WIN)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_reg    (bus_reg),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .supply_low (supply_low),
        .cpu_halt   (cpu_halt),
        .ready_irq  (ready_irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_data = 0; m_data_known = 1; m_arm = 0; m_win = 0;
            m_ie = 0; m_irq = 0; m_halt = 0; m_busy = 0;
        end else begin
            bit was_busy, was_arm, ctl;
            was_busy = (m_busy > 0);
            was_arm  = m_arm;
            m_irq = (m_busy == 1) && m_ie;
            if (m_busy > 0) begin
                m_busy--;
                if (m_busy == 0) mem[m_pa] = byte'(m_pd);
            end
            if (m_halt > 0) m_halt--;
            if (m_arm) begin
                if (m_win == 1) m_arm = 0; else m_win--;
            end
            ctl = bus_we && bus_reg == 2'd1;
            if (bus_we && !was_busy) begin
                if (bus_reg == 2'd0) begin m_data = bus_wdata; m_data_known = 1; end
                if (bus_reg == 2'd2) m_addr = (m_addr & 'hF00) | bus_wdata;
                if (bus_reg == 2'd3) begin
                    m_addr = (m_addr & 'h0FF) | ((bus_wdata & 'hF) << 8);
                    m_addr_known = 1;
                end
            end
            if (ctl) begin
                m_ie = bus_wdata[3];
                if (bus_wdata[1]) begin
                    m_arm = 0;
                    if (was_arm && !was_busy && !supply_low) begin
                        m_busy = WR_LAT; m_pa = m_addr; m_pd = m_data; m_halt = WR_HALT;
                    end
                end else begin
                    m_arm = bus_wdata[2];
                    m_win = ARM_WIN;
                    if (bus_wdata[0] && !was_busy) begin
                        m_halt = RD_HALT;
                        m_data_known = m_addr_known && mem.exists(m_addr);
                        if (m_data_known) m_data = mem[m_addr];
                    end
                end
            end
        end
    end

    task automatic check(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("cpu_halt", int'(cpu_halt), int'(m_halt > 0));
            check("ready_irq", int'(ready_irq), int'(m_irq));
            case (bus_reg)
                2'd0: if (m_data_known) check("data reg", bus_rdata, m_data);
                2'd1: check("control reg", bus_rdata,
                            (int'(m_ie) << 3) | (int'(m_arm) << 2) | (int'(m_busy > 0) << 1));
                2'd2: if (m_addr_known) check("addr low", bus_rdata, m_addr & 'hFF);
                default: begin
                    check("addr high reserved", int'(bus_rdata[7:4]), 0);
                    if (m_addr_known) check("addr high", bus_rdata, (m_addr >> 8) & 'hF);
                end
            endcase
        end
    end

    task automatic step(input logic we, input logic [1:0] r, input logic [7:0] v);
        @(posedge clk);
        #2;
        bus_we = we; bus_reg = r; bus_wdata = v;
    endtask

    task automatic idle(input int n, input logic [1:0] r);
        for (int i = 0; i < n; i++) step(1'b0, r, 8'h00);
    endtask

    task automatic set_addr(input int a);
        step(1'b1, 2'd2, 8'(a & 'hFF));
        step(1'b1, 2'd3, 8'((a >> 8) | 'hA0));
    endtask

    task automatic start_write(input int a, input int v);
        set_addr(a);
        step(1'b1, 2'd0, 8'(v));
        step(1'b1, 2'd1, {4'b0, ie_bit, 3'b100});
        step(1'b1, 2'd1, {4'b0, ie_bit, 3'b010});
    endtask

    task automatic do_write(input int a, input int v);
        start_write(a, v);
        idle(WR_LAT + 2, 2'd1);
    endtask

    task automatic do_read(input int a);
        set_addr(a);
        step(1'b1, 2'd1, {4'b0, ie_bit, 3'b001});
        idle(RD_HALT + 2, 2'd0);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R11: reset state of halt, interrupt, control and data
        tag = "R11";
        idle(2, 2'd1);
        idle(2, 2'd0);
        // R2: reserved bits of the high address register
        tag = "R2";
        step(1'b1, 2'd3, 8'hF5);
        idle(2, 2'd3);
        step(1'b1, 2'd3, 8'hA0);
        idle(1, 2'd3);
        // R1 and R4: store then load at several addresses
        tag = "R1 R4";
        do_write('h5A3, 'h3C);
        tag = "R3";
        do_read('h5A3);
        tag = "R1";
        for (int k = 0; k < 5; k++) begin
            int a;
            a = (k == 0) ? 'h000 : (k == 1) ? 'hFFF : (k == 2) ? 'h100 : (k == 3) ? 'h0FF : 'h800;
            do_write(a, (k * 37 + 11) & 'hFF);
        end
        for (int k = 0; k < 5; k++) begin
            int a;
            a = (k == 0) ? 'h000 : (k == 1) ? 'hFFF : (k == 2) ? 'h100 : (k == 3) ? 'h0FF : 'h800;
            do_read(a);
        end
        // R5: busy readback length
        tag = "R5";
        start_write('h321, 'h77);
        idle(WR_LAT + 3, 2'd1);
        // R8: register writes during busy are dropped
        tag = "R8";
        start_write('h044, 'h55);
        step(1'b1, 2'd2, 8'h11);
        step(1'b1, 2'd0, 8'h99);
        step(1'b1, 2'd3, 8'h02);
        idle(1, 2'd2);
        idle(1, 2'd0);
        // R7: load strobe during busy is dropped
        tag = "R7";
        step(1'b1, 2'd1, 8'h01);
        idle(WR_LAT + 2, 2'd0);
        idle(1, 2'd2);
        do_read('h044);
        // R6: arming window edges
        tag = "R6";
        set_addr('h600);
        step(1'b1, 2'd0, 8'hE1);
        step(1'b1, 2'd1, 8'h04);
        idle(3, 2'd1);
        step(1'b1, 2'd1, 8'h02);
        idle(WR_LAT + 2, 2'd1);
        step(1'b1, 2'd0, 8'hE2);
        step(1'b1, 2'd1, 8'h04);
        idle(4, 2'd1);
        step(1'b1, 2'd1, 8'h02);
        idle(3, 2'd1);
        step(1'b1, 2'd1, 8'h02);
        idle(3, 2'd1);
        step(1'b1, 2'd1, 8'h04);
        step(1'b1, 2'd1, 8'h00);
        step(1'b1, 2'd1, 8'h02);
        idle(3, 2'd1);
        do_read('h600);
        // R9: ready interrupt with and without enable
        tag = "R9";
        ie_bit = 1'b1;
        do_write('h0A5, 'h5A);
        ie_bit = 1'b0;
        do_write('h0A6, 'h6B);
        // R10: inhibit blocks start, not completion
        tag = "R10";
        supply_low = 1'b1;
        start_write('h0A5, 'hFF);
        idle(WR_LAT + 2, 2'd1);
        supply_low = 1'b0;
        do_read('h0A5);
        start_write('h7F0, 'hC3);
        step(1'b0, 2'd1, 8'h00);
        supply_low = 1'b1;
        idle(WR_LAT + 2, 2'd1);
        supply_low = 1'b0;
        do_read('h7F0);
        idle(2, 2'd0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule